// File: doc/BRIEF.md
# Early Completion Detector for Dual-Rail Dynamic Stages

This block watches the dual-rail inputs of a dynamic pipeline stage, not its outputs, and raises a done indication while the stage itself is evaluating or precharging. Because it looks at the inputs, the earlier stages receive their acknowledgement a full stage delay sooner than a detector placed after the stage would give. An early-done lookahead pipeline uses it as its completion element.

The state is held by an asymmetric C-element, modelled here as a clocked register. The set path needs two things: the stage control must select evaluate, and every dual-rail bit in the slice must carry a valid code. The reset path needs only one thing: the control must select precharge. When neither path is active, done keeps its value. A wide datapath is split into narrow lanes. Each lane has its own local detector and its own done output, so every detector has a small fan-in and drives only a few gates.

Top module: `ecd_detector_array`

## Requirements
- R1: While `rst_n` is low, every bit of `done_o` is 0.
- R2: When `eval_i` is 1 (evaluate) and every bit of a lane holds a valid code, that lane's done bit is 1 after the next rising clock edge. Lane l, bit b occupies `rails_i[2*(l*BITS+b) +: 2]`. A valid code is 2'b01 or 2'b10.
- R3: When `eval_i` is 0 (precharge), every lane's done bit is 0 after the next edge. This holds whatever the data, including fully valid data.
- R4: When `eval_i` is 1 and at least one bit of a lane is spacer (2'b00), that lane's done bit keeps its previous value across the edge.
- R5: A bit with both rails high (2'b11) is not a valid code. While evaluating, it behaves like a spacer for that lane: done holds.
- R6: After precharge, if the control switches to evaluate while the inputs are still spacer, done stays 0 until every bit of the lane becomes valid. It rises on the edge that first sees the lane fully valid.
- R7: Each lane's done depends only on its own bits and `eval_i`. The data of one lane never changes another lane's done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Stage control: 1 = evaluate, 0 = precharge |
| rails_i | input | 2*LANES*BITS | Dual-rail input pairs, {rail1, rail0} for each bit |
| done_o | output | LANES | Early done, one bit for each local detector |

## Verification
Two cases put the set and reset functions against each other. In the first, precharge arrives while the inputs are still fully valid. The data would keep setting done, but the control must win, so done falls on the next edge. In the second, one lane meets its set condition in the same cycle that a neighbouring lane only holds. The bench provokes both with directed steps and with a long random run that mixes valid, spacer and illegal codes with both control values. A queue-based reference model of the set, hold and reset rules judges done on every lane one edge after each stimulus.

// File: rtl/ecd_pkg.sv
package ecd_pkg;
  // A dual-rail pair is a valid code when exactly one rail is high.
  function automatic logic pair_valid(input logic [1:0] pair);
    return pair[1] ^ pair[0];
  endfunction

  // Next state of the asymmetric C-element: clear wins, set next, else hold.
  function automatic logic celem_next(input logic q, input logic set_c, input logic clr_c);
    if (clr_c)      return 1'b0;
    else if (set_c) return 1'b1;
    else            return q;
  endfunction
endpackage

// File: rtl/ecd_rail_decode.sv
module ecd_rail_decode #(
  parameter int BITS = 4
) (
  input  logic [2*BITS-1:0] rails_i,
  output logic [BITS-1:0]   bit_ok_o
);
  import ecd_pkg::*;

  for (genvar b = 0; b < BITS; b++) begin : g_bit
    assign bit_ok_o[b] = pair_valid(rails_i[2*b +: 2]);
  end
endmodule

// File: rtl/ecd_asym_celem.sv
module ecd_asym_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import ecd_pkg::*;

  logic q_q;

  always_ff @(posedge clk) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= celem_next(q_q, set_i, clr_i);
  end

  assign q_o = q_q;

  // R3: the reset path wins over the data
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  // R2: set while not clearing
  a_r2_set_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  // R4: hold when neither path is active
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/ecd_lane.sv
module ecd_lane #(
  parameter int BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [2*BITS-1:0] rails_i,
  output logic              done_o
);
  logic [BITS-1:0] bit_ok;
  logic            lane_valid;
  logic            set_ev;
  logic            clr_ev;

  ecd_rail_decode #(.BITS(BITS)) u_dec (
    .rails_i (rails_i),
    .bit_ok_o(bit_ok)
  );

  assign lane_valid = &bit_ok;
  assign set_ev     = eval_i & lane_valid;
  assign clr_ev     = ~eval_i;

  ecd_asym_celem u_cel (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(set_ev),
    .clr_i(clr_ev),
    .q_o  (done_o)
  );

  // R6: done only rises after an evaluate cycle with a fully valid lane
  a_r6_rise_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(eval_i && lane_valid));
  // R5: an illegal 11 code never counts as valid
  a_r5_illegal_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && (bit_ok != {BITS{1'b1}})) |=> $stable(done_o));
endmodule

// File: rtl/ecd_detector_array.sv
module ecd_detector_array #(
  parameter int LANES = 2,
  parameter int BITS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      eval_i,
  input  logic [2*LANES*BITS-1:0]   rails_i,
  output logic [LANES-1:0]          done_o
);
  localparam int LANE_W = 2 * BITS;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ecd_lane #(.BITS(BITS)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .eval_i (eval_i),
      .rails_i(rails_i[l*LANE_W +: LANE_W]),
      .done_o (done_o[l])
    );
  end

  // R1: reset state seen at the ports
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |=> (done_o == '0));
  // R3: precharge clears every lane
  a_r3_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> (done_o == '0));
endmodule

// File: tb/ecd_detector_array_tb.sv
module ecd_detector_array_tb_top;
  localparam int LANES = 2;
  localparam int BITS  = 4;
  localparam int W     = 2 * LANES * BITS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             eval_i = 1'b0;
  logic [W-1:0]     rails_i = '0;
  logic [LANES-1:0] done_o;

  always #2 clk = ~clk;

  ecd_detector_array #(.LANES(LANES), .BITS(BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .rails_i(rails_i), .done_o(done_o)
  );

  typedef struct {
    logic [LANES-1:0] exp;
    string            req;
  } exp_t;

  exp_t             sb_q[$];
  logic [LANES-1:0] model_q = '0;
  int               checks = 0;
  int               errors = 0;
  bit               finished = 0;

  // Reference: a lane is ready when each pair is 01 or 10.
  function automatic logic lane_ready(input logic [W-1:0] r, input int l);
    for (int b = 0; b < BITS; b++) begin
      logic [1:0] p;
      p = r[2*(l*BITS+b) +: 2];
      if (!(p == 2'b01 || p == 2'b10)) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic drive(input logic ev, input logic [W-1:0] r, input string req);
    exp_t e;
    @(negedge clk);
    eval_i  = ev;
    rails_i = r;
    for (int l = 0; l < LANES; l++) begin
      if (!ev)                   model_q[l] = 1'b0;
      else if (lane_ready(r, l)) model_q[l] = 1'b1;
    end
    e.exp = model_q;
    e.req = req;
    sb_q.push_back(e);
  endtask

  // Monitor: after each edge, compare against the oldest expectation.
  always @(posedge clk) begin
    #1;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (done_o !== e.exp) begin
        errors++;
        $display("FAIL %s: done_o=%b expected=%b", e.req, done_o, e.exp);
      end
    end
  end

  function automatic logic [1:0] pick_code(input int sel);
    case (sel)
      0: return 2'b01;
      1: return 2'b10;
      2: return 2'b00;
      default: return 2'b11;
    endcase
  endfunction

  localparam logic [7:0] LANE_VALID = 8'b01_10_10_01;
  localparam logic [7:0] LANE_SPACE = 8'b00_00_00_00;
  localparam logic [7:0] LANE_PART  = 8'b01_00_10_01;
  localparam logic [7:0] LANE_ILL   = 8'b01_11_10_01;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (done_o !== '0) begin
      errors++;
      $display("FAIL R1: done_o=%b expected=%b", done_o, {LANES{1'b0}});
    end
    @(negedge clk);
    rst_n = 1'b1;

    drive(1'b1, {LANE_SPACE, LANE_SPACE}, "R6");  // evaluate on spacer: stays low
    drive(1'b1, {LANE_PART,  LANE_PART},  "R6");
    drive(1'b1, {LANE_VALID, LANE_VALID}, "R2");  // both lanes valid: rise
    drive(1'b1, {LANE_SPACE, LANE_PART},  "R4");  // hold high
    drive(1'b0, {LANE_VALID, LANE_VALID}, "R3");  // precharge wins over valid data
    drive(1'b1, {LANE_ILL,   LANE_ILL},   "R5");  // 11 code: no set
    drive(1'b1, {LANE_SPACE, LANE_VALID}, "R7");  // lane 0 only
    drive(1'b1, {LANE_ILL,   LANE_SPACE}, "R5");  // lane 0 holds high, lane 1 holds low
    drive(1'b1, {LANE_VALID, LANE_PART},  "R7");  // lane 1 rises
    drive(1'b0, {LANE_SPACE, LANE_SPACE}, "R3");
    drive(1'b1, {LANE_SPACE, LANE_SPACE}, "R6");

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] r;
      logic         ev;
      ev = ($urandom_range(0, 9) < 7);
      for (int l = 0; l < LANES; l++) begin
        bit all_ok;
        all_ok = ($urandom_range(0, 1) == 1);
        for (int b = 0; b < BITS; b++)
          r[2*(l*BITS+b) +: 2] = all_ok ? pick_code($urandom_range(0, 1))
                                        : pick_code($urandom_range(0, 3));
      end
      drive(ev, r, "R4");
    end
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule